// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Staged Edge Updates

This block drives a bank of pulse-width-modulated outputs from one shared period counter. Each channel owns a rise compare value, a fall compare value and an enable bit. Its output is high while the counter is inside the window from the rise value up to, but not including, the fall value. The period register sets the counter's top value, and the counter wraps to zero after reaching it.

A build-time mask picks, channel by channel, how compare writes are applied. An unmasked channel takes a new compare value at once, and the waveform may glitch. A masked channel holds writes in a staging copy. Software writes every staged value and then raises the update request. The staged values move to the live registers together at the first end of period after the request, and the request then clears. While any channel is masked, the period register is staged in the same way. Readback always returns the live values, so software can poll the request flag to learn when a commit has happened. Enable bits always act at once.

Top module: `pwm_bank`

## Requirements
- R1: The counter counts 0, 1, … up to the live period value and then wraps to 0, so one period lasts period+1 cycles. The period register is at address 0x00.
- R2: An enabled channel's output is high for exactly the cycles in which the counter value c satisfies rise ≤ c < fall. With a steady configuration this gives fall−rise high cycles per period when fall ≤ period+1. The output is registered and lags the counter by one clock.
- R3: A channel's output stays low whenever rise ≥ fall or the channel is disabled.
- R4: Channels 0–7 are enabled by bit (ch mod 8) of address 0x01, and channels 8–15 by bit (ch mod 8) of address 0x02. A cleared bit forces the output low by the second rising clock edge after the write cycle, on shadowed and unshadowed channels alike.
- R5: Channel ch has its rise value at address 0x10+2·ch and its fall value at 0x11+2·ch. On an unshadowed channel a write there becomes live and readable at once.
- R6: On a shadowed channel, reading a rise or fall address returns the live value until a commit copies the staged value.
- R7: Staged values (shadowed edges, and the period when any channel is shadowed) become live only after a write with bit 0 set to address 0x03. They commit at the first end of period after that write, never in the middle of a period.
- R8: Reading address 0x03 returns 1 while an update request is pending and 0 after the commit. A write to 0x03 with bit 0 clear does nothing.
- R9: A staged write made after a commit stays staged, with no effect on the output or on readback, until the next update request is committed.
- R10: With a nonzero shadow mask, a period write is staged and reads back the old value until committed.
- R11: After reset all registers read 0, no request is pending and all outputs are low.
- R12: Read data appears on the clock after the read strobe. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (6) | Write address |
| wr_data | input | CW (16) | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW (6) | Read address |
| rd_data | output | CW (16) | Read data, valid the cycle after rd_en |
| pwm_out | output | NCH (16) | Channel waveforms |

## Verification
A counter that fails to wrap shows up within one period as a wrong high-cycle count and a wrong distance between rising edges. A staging copy that leaks into the live registers shows up at once in readback and within one period on the output. A pending flag that clears early or sticks is seen by polling address 0x03. The bench starts each request at a known counter phase, taken from a channel's rising edge, so a commit made before the end of period is caught by the flag clearing too soon. It would also show as a changed duty count within the same period.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int unsigned ADDR_PERIOD    = 0;
  localparam int unsigned ADDR_EN_LO     = 1;
  localparam int unsigned ADDR_EN_HI     = 2;
  localparam int unsigned ADDR_SYNC      = 3;
  localparam int unsigned ADDR_EDGE_BASE = 16;
  localparam int unsigned EN_BANK_BITS   = 8;

  // True while the counter lies in the channel's high window.
  function automatic logic edge_hit(input int unsigned cnt,
                                    input int unsigned rise,
                                    input int unsigned fall);
    return (cnt >= rise) && (cnt < fall);
  endfunction

  function automatic int unsigned rise_addr(input int unsigned ch);
    return ADDR_EDGE_BASE + 2 * ch;
  endfunction

  function automatic int unsigned fall_addr(input int unsigned ch);
    return ADDR_EDGE_BASE + 2 * ch + 1;
  endfunction

  function automatic int unsigned en_addr(input int unsigned ch);
    return ADDR_EN_LO + ch / EN_BANK_BITS;
  endfunction

  function automatic int unsigned en_bit(input int unsigned ch);
    return ch % EN_BANK_BITS;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 16,
  parameter bit PERIOD_SHADOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_period,
  input  logic [CW-1:0] wr_data,
  input  logic          commit,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] period_o,
  output logic          period_end_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] per_live_q;

  assign period_end_o = (cnt_q >= per_live_q);
  assign cnt_o        = cnt_q;
  assign period_o     = per_live_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (period_end_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PERIOD_SHADOW) begin : g_staged
      logic [CW-1:0] per_stage_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          per_stage_q <= '0;
          per_live_q  <= '0;
        end else begin
          if (wr_period) per_stage_q <= wr_data;
          if (commit)    per_live_q  <= per_stage_q;
        end
      end
      // R10: the live period moves only on a commit
      a_r10_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(per_live_q));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)         per_live_q <= '0;
        else if (wr_period) per_live_q <= wr_data;
      end
    end
  endgenerate

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> cnt_q == '0);
  a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end_o |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/pwm_sync_ctl.sv
module pwm_sync_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic period_end,
  output logic pending_o,
  output logic commit_o
);

  logic pending_q;

  assign pending_o = pending_q;
  assign commit_o  = pending_q & period_end;

  always_ff @(posedge clk) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (req_set)  pending_q <= 1'b1;
    else if (commit_o) pending_q <= 1'b0;
  end

  // R7: a pending request survives until a period ends
  a_r7_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !period_end |=> pending_q);
  // R8: the flag drops after the commit unless re-requested
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o && !req_set |=> !pending_q);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter bit SHADOWED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [CW-1:0] wr_data,
  input  logic          commit,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] rise_o,
  output logic [CW-1:0] fall_o,
  output logic          out_o
);

  logic [CW-1:0] rise_live_q;
  logic [CW-1:0] fall_live_q;
  logic          out_q;
  logic          hit;

  assign rise_o = rise_live_q;
  assign fall_o = fall_live_q;
  assign out_o  = out_q;
  assign hit    = edge_hit(32'(cnt), 32'(rise_live_q), 32'(fall_live_q));

  generate
    if (SHADOWED) begin : g_staged
      logic [CW-1:0] rise_stage_q;
      logic [CW-1:0] fall_stage_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rise_stage_q <= '0;
          fall_stage_q <= '0;
          rise_live_q  <= '0;
          fall_live_q  <= '0;
        end else begin
          if (wr_rise) rise_stage_q <= wr_data;
          if (wr_fall) fall_stage_q <= wr_data;
          if (commit) begin
            rise_live_q <= rise_stage_q;
            fall_live_q <= fall_stage_q;
          end
        end
      end
      // R6: live edges of a staged channel move only on a commit
      a_r6_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rise_live_q) && $stable(fall_live_q));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rise_live_q <= '0;
          fall_live_q <= '0;
        end else begin
          if (wr_rise) rise_live_q <= wr_data;
          if (wr_fall) fall_live_q <= wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= en & hit;
  end

  a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_o);
  a_r3_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_live_q >= fall_live_q) |=> !out_o);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 6,
  parameter logic [NCH-1:0] SHADOW_MASK = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out
);

  localparam bit PERIOD_SHADOW = |SHADOW_MASK;

  logic [CW-1:0]  cnt;
  logic [CW-1:0]  period_live;
  logic           period_end;
  logic           pending;
  logic           commit;
  logic           wr_period;
  logic           sync_set;
  logic [NCH-1:0] en_q;
  logic [CW-1:0]  rise_live [NCH];
  logic [CW-1:0]  fall_live [NCH];
  logic [CW-1:0]  rd_mux;
  logic [CW-1:0]  rd_data_q;

  assign wr_period = wr_en && (wr_addr == AW'(ADDR_PERIOD));
  assign sync_set  = wr_en && (wr_addr == AW'(ADDR_SYNC)) && wr_data[0];

  pwm_timebase #(.CW(CW), .PERIOD_SHADOW(PERIOD_SHADOW)) u_timebase (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_period    (wr_period),
    .wr_data      (wr_data),
    .commit       (commit),
    .cnt_o        (cnt),
    .period_o     (period_live),
    .period_end_o (period_end)
  );

  pwm_sync_ctl u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_set    (sync_set),
    .period_end (period_end),
    .pending_o  (pending),
    .commit_o   (commit)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int unsigned EA = en_addr(i);
      localparam int unsigned EB = en_bit(i);
      logic wr_rise;
      logic wr_fall;

      assign wr_rise = wr_en && (wr_addr == AW'(rise_addr(i)));
      assign wr_fall = wr_en && (wr_addr == AW'(fall_addr(i)));

      always_ff @(posedge clk) begin
        if (!rst_n)                                en_q[i] <= 1'b0;
        else if (wr_en && (wr_addr == AW'(EA)))    en_q[i] <= wr_data[EB];
      end

      pwm_chan #(.CW(CW), .SHADOWED(SHADOW_MASK[i])) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_rise (wr_rise),
        .wr_fall (wr_fall),
        .wr_data (wr_data),
        .commit  (commit),
        .en      (en_q[i]),
        .cnt     (cnt),
        .rise_o  (rise_live[i]),
        .fall_o  (fall_live[i]),
        .out_o   (pwm_out[i])
      );
    end
  endgenerate

  // Readback always shows live values.
  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(ADDR_PERIOD)) rd_mux = period_live;
    if (rd_addr == AW'(ADDR_SYNC))   rd_mux = CW'(pending);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(en_addr(i)))   rd_mux[en_bit(i)] = en_q[i];
      if (rd_addr == AW'(rise_addr(i))) rd_mux = rise_live[i];
      if (rd_addr == AW'(fall_addr(i))) rd_mux = fall_live[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_mux;
  end

  assign rd_data = rd_data_q;

  // R4: a cleared enable forces the output low on the following edge
  a_r4_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q[0]) |=> !pwm_out[0]);
  // R11/R7: no commit happens without a pending request
  a_r7_commit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !commit);

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;

  localparam int NCH = 16;
  localparam int CW  = 16;
  localparam int AW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic           rd_en = 1'b0;
  logic [AW-1:0]  rd_addr = '0;
  logic [CW-1:0]  rd_data;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank #(.NCH(NCH), .CW(CW), .AW(AW), .SHADOW_MASK(16'h00F0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  typedef struct {
    string req;
    int    ch;
    int    win;
    int    exp;
  } duty_item_t;

  duty_item_t sb_q[$];
  int sb_items = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    data = int'(rd_data);
  endtask

  task automatic rd_check(input string req, input int addr, input int exp);
    int v;
    rd(addr, v);
    check(req, v, exp);
  endtask

  // Poll the update flag; returns the number of reads needed.
  task automatic poll_sync(input string req, output int n);
    int v;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      rd(3, v);
      n++;
      if (v == 0) break;
    end
    if (v != 0) check(req, v, 0);
  endtask

  task automatic commit_now(input string req);
    int n;
    wr(3, 1);
    poll_sync(req, n);
  endtask

  // Driver side of the scoreboard: queue an expected duty, wait for the monitor.
  task automatic expect_duty(input string req, input int ch, input int win, input int exp);
    duty_item_t it;
    it.req = req; it.ch = ch; it.win = win; it.exp = exp;
    sb_q.push_back(it);
    sb_items++;
    wait (sb_items == 0);
  endtask

  // Monitor side: counts high cycles of one output over a window.
  initial begin
    forever begin
      duty_item_t it;
      int hi;
      wait (sb_items > 0);
      it = sb_q[0];
      hi = 0;
      for (int k = 0; k < it.win; k++) begin
        @(negedge clk);
        if (pwm_out[it.ch]) hi++;
      end
      check(it.req, hi, it.exp);
      void'(sb_q.pop_front());
      sb_items--;
    end
  end

  function automatic int ra(input int ch); return 16 + 2 * ch; endfunction
  function automatic int fa(input int ch); return 17 + 2 * ch; endfunction

  initial begin
    int n;
    int t0;
    int t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 outputs after reset", int'(pwm_out), 0);
    rd_check("R11 period after reset", 0, 0);
    rd_check("R11 sync after reset", 3, 0);
    rd_check("R11 enable after reset", 1, 0);

    // R10 staged period, R1 commit
    wr(0, 9);
    rd_check("R10 period staged", 0, 0);
    commit_now("R8 flag clears");
    rd_check("R10 period committed", 0, 9);

    // R5 immediate channel, R2 duty
    wr(ra(0), 2); wr(fa(0), 6);
    rd_check("R5 rise readback", ra(0), 2);
    rd_check("R5 fall readback", fa(0), 6);
    wr(1, 'h01);
    repeat (2) @(negedge clk);
    expect_duty("R2 ch0 2..6", 0, 10, 4);

    // R4 upper enable register, fall beyond period
    wr(ra(9), 0); wr(fa(9), 10);
    wr(2, 'h02);
    repeat (2) @(negedge clk);
    expect_duty("R4 ch9 enabled via upper bank", 9, 10, 10);
    expect_duty("R4 ch8 stays disabled", 8, 10, 0);
    rd_check("R4 upper enable readback", 2, 'h02);

    // R3 empty window
    wr(ra(1), 5); wr(fa(1), 5);
    wr(1, 'h03);
    repeat (2) @(negedge clk);
    expect_duty("R3 rise equals fall", 1, 10, 0);

    // R4 disable takes effect at once
    wr(1, 'h02);
    @(negedge clk);
    check("R4 ch0 low after disable", int'(pwm_out[0]), 0);
    expect_duty("R4 ch0 disabled window", 0, 10, 0);

    // R6 staged channel readback, R7 no commit without request
    wr(ra(4), 1); wr(fa(4), 4);
    rd_check("R6 staged rise reads live", ra(4), 0);
    wr(1, 'h12);
    repeat (30) @(negedge clk);
    rd_check("R7 no commit without request", fa(4), 0);
    expect_duty("R7 staged ch4 idle", 4, 10, 0);
    commit_now("R8 flag clears ch4");
    rd_check("R7 rise after commit", ra(4), 1);
    rd_check("R7 fall after commit", fa(4), 4);
    repeat (2) @(negedge clk);
    expect_duty("R7 ch4 duty after commit", 4, 10, 3);

    // R9 write after commit stays staged
    wr(fa(4), 8);
    repeat (25) @(negedge clk);
    rd_check("R9 later write stays staged", fa(4), 4);
    expect_duty("R9 ch4 duty unchanged", 4, 10, 3);
    commit_now("R8 flag clears again");
    rd_check("R9 committed on next request", fa(4), 8);
    repeat (2) @(negedge clk);
    expect_duty("R9 ch4 new duty", 4, 10, 7);

    // R4 shadowed channel enable acts at once
    wr(1, 'h02);
    repeat (2) @(negedge clk);
    expect_duty("R4 shadowed ch4 disabled", 4, 10, 0);
    wr(1, 'h12);

    // Long period for phase-aware checks
    wr(0, 99);
    commit_now("R8 flag clears period 99");
    rd_check("R10 long period committed", 0, 99);

    // R1 distance between rising edges of ch4 equals period+1
    @(negedge clk);
    while (pwm_out[4]) @(negedge clk);
    while (!pwm_out[4]) @(negedge clk);
    t0 = cyc;
    while (pwm_out[4]) @(negedge clk);
    while (!pwm_out[4]) @(negedge clk);
    t1 = cyc;
    check("R1 period length", t1 - t0, 100);

    // R7/R8: request made early in a period commits only at its end
    wr(ra(5), 10); wr(fa(5), 20);
    wr(1, 'h32);
    while (pwm_out[4]) @(negedge clk);
    while (!pwm_out[4]) @(negedge clk);
    t0 = cyc;
    wr(3, 1);
    rd_check("R8 flag set while pending", 3, 1);
    repeat (40) @(negedge clk);
    rd_check("R7 no commit mid period", 3, 1);
    rd_check("R6 ch5 rise still live value", ra(5), 0);
    poll_sync("R7 commit at period end", n);
    t1 = cyc;
    checks++;
    if ((t1 - t0) < 90 || (t1 - t0) > 103) begin
      errors++;
      $display("FAIL R7 commit delay: actual=%0d expected=90..103", t1 - t0);
    end
    rd_check("R7 ch5 rise committed", ra(5), 10);
    repeat (2) @(negedge clk);
    expect_duty("R2 ch5 duty long period", 5, 100, 10);
    expect_duty("R2 ch4 duty long period", 4, 100, 7);

    // R8 write with bit0 clear does nothing
    wr(3, 'h2);
    rd_check("R8 clear-bit write ignored", 3, 0);

    // R12 unmapped addresses
    rd_check("R12 unmapped 0x04", 4, 0);
    rd_check("R12 unmapped 0x3F", 'h3F, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule